// File: doc/BRIEF.md
# Transceiver Reconfiguration Command Sequencer

This block is the control engine that reprograms a group of transceiver lanes and their transmit PLLs through a memory-mapped management window. After a start pulse it visits every reconfiguration target in turn. There are twice as many targets as lanes: first every lane channel, then every transmit PLL. For each target it selects the target, clears the mode field by read-modify-write, and then runs two streamer phases. The first phase loads the image base address. The second phase arms streaming. Each phase ends with a launch followed by busy polling.

The sequencer acts as a simple memory-mapped master. It uses a wait-request stall and a separately timed read-data-valid strobe. A programmable poll budget bounds every busy wait. When the budget runs out, the sequencer halts, raises an error flag and exposes the index of the target that stalled. A clean run ends with a one-cycle done pulse.

Top module: `xcvrReconfSeq`

## Requirements
- R1: Targets are visited in index order 0 to 2L-1, where L is `laneCount`. Each target begins with a write of its own index to offset 0x38.
- R2: For each target the bus accesses follow this fixed order. Write 0x38 = index. Read 0x3A. Write 0x3A. Write 0x3B = 0. Write 0x3C = `BASE_ADDR` (default 32'h1000). Write 0x3A (launch). Poll 0x3A. Write 0x3B = 1. Write 0x3C = 3. Write 0x3A (launch). Poll 0x3A.
- R3: Control word read-modify-write. The value read from 0x3A is written back with bits [3:2] cleared and every other bit kept. Each launch write sends that same value with bit 0 set.
- R4: After each launch, offset 0x3A is read repeatedly while the returned bit 8 is 1. No further write is issued until a read returns bit 8 = 0.
- R5: While `avWaitReq` is high, a pending request keeps its address, its write data and its read/write strobes unchanged. Read data is taken only in the cycle `avReadValid` is high. Reads and writes are never asserted together.
- R6: If the busy flag reads as 1 on `pollLimit` consecutive polls within one phase, the sequencer stops issuing accesses. It holds `error` high and shows the stalled target index on `failIndex` until the next start.
- R7: `done` is high for exactly one cycle after the final poll of target 2L-1 completes. With `laneCount` = 0, a start produces the done pulse and no bus access.
- R8: A start pulse that arrives while a sequence is running has no effect on the access stream or on the number of done pulses.
- R9: After reset, `done`, `error`, `avWrite` and `avRead` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Start pulse, accepted when idle or halted |
| laneCount | input | LANE_W | Number of lanes L, sampled at start |
| pollLimit | input | TMO_W | Busy reads allowed per phase before error |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Held high after a poll timeout |
| failIndex | output | LANE_W+1 | Target index at the time of the error |
| avAddr | output | 6 | Register offset |
| avWrite | output | 1 | Write request |
| avRead | output | 1 | Read request |
| avWriteData | output | 32 | Write data |
| avReadData | input | 32 | Read data |
| avWaitReq | input | 1 | Slave stall |
| avReadValid | input | 1 | Read data valid |

## Verification
The bench keeps the default parameters: `LANE_W` = 4 and `TMO_W` = 16, with `BASE_ADDR` = 32'h1000. It drives lane counts from 0 to 4, so runs cover both a single target pair and eight targets, where the channel-to-PLL switch falls in the middle. The poll limit is set to 8 on clean runs and to 3 on runs meant to time out. The slave model's busy depth is kept below or above that limit, so both a stall on target 0 and a stall on the last PLL target can be reached. Random wait-request stalls and read latencies of 1 to 3 cycles exercise the request-hold rule at every step.

// File: rtl/reconfSeqPkg.sv
package reconfSeqPkg;
  localparam logic [5:0] OFS_TARGET  = 6'h38;
  localparam logic [5:0] OFS_CTRL    = 6'h3A;
  localparam logic [5:0] OFS_STROFS  = 6'h3B;
  localparam logic [5:0] OFS_STRDATA = 6'h3C;
  localparam logic [31:0] MODE_MASK  = 32'h0000_000C;
  localparam logic [31:0] LAUNCH_BIT = 32'h0000_0001;
  localparam int          BUSY_POS   = 8;
  localparam logic [31:0] ARM_WORD   = 32'd3;
  localparam logic [3:0]  LAST_STEP  = 4'd10;

  typedef struct packed {
    logic clear;    // restart target and step counters
    logic advance;  // current access completed, move on
    logic capture;  // store read-modify-write source word
    logic pollMiss; // a poll returned busy
  } seqStrobeT;
endpackage

// File: rtl/seqDatapath.sv
module seqDatapath
  import reconfSeqPkg::*;
#(
  parameter int LANE_W = 4,
  parameter int TMO_W = 16,
  parameter logic [31:0] BASE_ADDR = 32'h1000,
  localparam int IDX_W = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobeT         st,
  input  logic [LANE_W-1:0] laneCount,
  input  logic [TMO_W-1:0]  pollLimit,
  input  logic [31:0]       avReadData,
  output logic [5:0]        avAddr,
  output logic [31:0]       avWriteData,
  output logic              isRead,
  output logic              isPoll,
  output logic              lastStep,
  output logic              lastTarget,
  output logic              busyBit,
  output logic              pollExhaust,
  output logic [IDX_W-1:0]  targetIdx
);
  logic [3:0]        step;
  logic [IDX_W-1:0]  target;
  logic [LANE_W-1:0] laneReg;
  logic [31:0]       shadow;
  logic [TMO_W-1:0]  pollCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      step <= '0;
      target <= '0;
      laneReg <= '0;
      shadow <= '0;
      pollCnt <= '0;
    end else begin
      if (st.clear) begin
        step <= '0;
        target <= '0;
        laneReg <= laneCount;
        pollCnt <= '0;
      end else if (st.advance) begin
        pollCnt <= '0;
        if (step == LAST_STEP) begin
          step <= '0;
          target <= target + 1'b1;
        end else begin
          step <= step + 1'b1;
        end
      end else if (st.pollMiss) begin
        pollCnt <= pollCnt + 1'b1;
      end
      if (st.capture) shadow <= avReadData & ~MODE_MASK;
    end
  end

  always_comb begin
    isRead = 1'b0;
    isPoll = 1'b0;
    avAddr = OFS_CTRL;
    avWriteData = '0;
    case (step)
      4'd0: begin avAddr = OFS_TARGET; avWriteData = {{(32-IDX_W){1'b0}}, target}; end
      4'd1: isRead = 1'b1;
      4'd2: avWriteData = shadow;
      4'd3: avAddr = OFS_STROFS;
      4'd4: begin avAddr = OFS_STRDATA; avWriteData = BASE_ADDR; end
      4'd5: avWriteData = shadow | LAUNCH_BIT;
      4'd7: begin avAddr = OFS_STROFS; avWriteData = 32'd1; end
      4'd8: begin avAddr = OFS_STRDATA; avWriteData = ARM_WORD; end
      4'd9: avWriteData = shadow | LAUNCH_BIT;
      default: begin isRead = 1'b1; isPoll = 1'b1; end
    endcase
  end

  assign lastStep    = (step == LAST_STEP);
  assign lastTarget  = (target == ({1'b0, laneReg} << 1) - 1'b1);
  assign busyBit     = avReadData[BUSY_POS];
  assign pollExhaust = ({1'b0, pollCnt} + 1'b1) >= {1'b0, pollLimit};
  assign targetIdx   = target;
endmodule

// File: rtl/seqControl.sv
module seqControl
  import reconfSeqPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      startReq,
  input  logic      laneZero,
  input  logic      isRead,
  input  logic      isPoll,
  input  logic      lastStep,
  input  logic      lastTarget,
  input  logic      busyBit,
  input  logic      pollExhaust,
  input  logic      avWaitReq,
  input  logic      avReadValid,
  output seqStrobeT st,
  output logic      avWrite,
  output logic      avRead,
  output logic      done,
  output logic      error
);
  typedef enum logic [1:0] {S_IDLE, S_ACCESS, S_RWAIT, S_HALT} stateT;
  stateT state, nextState;
  logic doneSet;

  always_comb begin
    st = '0;
    doneSet = 1'b0;
    nextState = state;
    case (state)
      S_IDLE, S_HALT: begin
        if (startReq) begin
          if (laneZero) begin
            doneSet = 1'b1;
            nextState = S_IDLE;
          end else begin
            st.clear = 1'b1;
            nextState = S_ACCESS;
          end
        end
      end
      S_ACCESS: begin
        if (!avWaitReq) begin
          if (isRead) nextState = S_RWAIT;
          else st.advance = 1'b1;
        end
      end
      default: begin
        if (avReadValid) begin
          if (isPoll && busyBit) begin
            if (pollExhaust) nextState = S_HALT;
            else begin
              st.pollMiss = 1'b1;
              nextState = S_ACCESS;
            end
          end else begin
            st.capture = !isPoll;
            st.advance = 1'b1;
            if (lastStep && lastTarget) begin
              doneSet = 1'b1;
              nextState = S_IDLE;
            end else begin
              nextState = S_ACCESS;
            end
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= S_IDLE;
      done <= 1'b0;
    end else begin
      state <= nextState;
      done <= doneSet;
    end
  end

  assign avWrite = (state == S_ACCESS) && !isRead;
  assign avRead  = (state == S_ACCESS) && isRead;
  assign error   = (state == S_HALT);
endmodule

// File: rtl/xcvrReconfSeq.sv
module xcvrReconfSeq
  import reconfSeqPkg::*;
#(
  parameter int LANE_W = 4,
  parameter int TMO_W = 16,
  parameter logic [31:0] BASE_ADDR = 32'h1000,
  localparam int IDX_W = LANE_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic [LANE_W-1:0] laneCount,
  input  logic [TMO_W-1:0]  pollLimit,
  output logic              done,
  output logic              error,
  output logic [IDX_W-1:0]  failIndex,
  output logic [5:0]        avAddr,
  output logic              avWrite,
  output logic              avRead,
  output logic [31:0]       avWriteData,
  input  logic [31:0]       avReadData,
  input  logic              avWaitReq,
  input  logic              avReadValid
);
  seqStrobeT st;
  logic isRead, isPoll, lastStep, lastTarget, busyBit, pollExhaust;

  seqControl u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .laneZero(laneCount == '0),
    .isRead(isRead), .isPoll(isPoll), .lastStep(lastStep), .lastTarget(lastTarget),
    .busyBit(busyBit), .pollExhaust(pollExhaust), .avWaitReq(avWaitReq),
    .avReadValid(avReadValid), .st(st), .avWrite(avWrite), .avRead(avRead),
    .done(done), .error(error)
  );

  seqDatapath #(.LANE_W(LANE_W), .TMO_W(TMO_W), .BASE_ADDR(BASE_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .laneCount(laneCount), .pollLimit(pollLimit),
    .avReadData(avReadData), .avAddr(avAddr), .avWriteData(avWriteData),
    .isRead(isRead), .isPoll(isPoll), .lastStep(lastStep), .lastTarget(lastTarget),
    .busyBit(busyBit), .pollExhaust(pollExhaust), .targetIdx(failIndex)
  );
endmodule

// File: rtl/reconfSeqChecker.sv
module reconfSeqChecker (
  input logic        clk,
  input logic        rstN,
  input logic        done,
  input logic        error,
  input logic [5:0]  avAddr,
  input logic        avWrite,
  input logic        avRead,
  input logic [31:0] avWriteData,
  input logic        avWaitReq
);
  p_hold_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (avWrite && avWaitReq) |=> (avWrite && $stable(avAddr) && $stable(avWriteData)));
  p_hold_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    (avRead && avWaitReq) |=> (avRead && $stable(avAddr)));
  p_no_both_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(avWrite && avRead));
  p_read_ctrl_only_r4: assert property (@(posedge clk) disable iff (!rstN)
    avRead |-> (avAddr == 6'h3A));
  p_addr_window_r2: assert property (@(posedge clk) disable iff (!rstN)
    avWrite |-> (avAddr inside {6'h38, 6'h3A, 6'h3B, 6'h3C}));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  p_halt_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    error |-> (!avWrite && !avRead && !done));
endmodule

bind xcvrReconfSeq reconfSeqChecker u_chk (
  .clk(clk), .rstN(rstN), .done(done), .error(error), .avAddr(avAddr),
  .avWrite(avWrite), .avRead(avRead), .avWriteData(avWriteData), .avWaitReq(avWaitReq)
);

// File: tb/tb_xcvrReconfSeq.sv
module tb_xcvrReconfSeq;
  localparam int LANE_W = 4;
  localparam int TMO_W = 16;
  localparam logic [31:0] BASE = 32'h1000;
  localparam int LOG_MAX = 1024;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic [LANE_W-1:0] laneCount = '0;
  logic [TMO_W-1:0] pollLimit = 16'd8;
  logic done, error;
  logic [LANE_W:0] failIndex;
  logic [5:0] avAddr;
  logic avWrite, avRead;
  logic [31:0] avWriteData;
  logic [31:0] avReadData = '0;
  logic avWaitReq = 1'b0;
  logic avReadValid = 1'b0;

  always #4 clk = ~clk;

  xcvrReconfSeq #(.LANE_W(LANE_W), .TMO_W(TMO_W), .BASE_ADDR(BASE)) dut (.*);

  int total = 0, bad = 0, cycles = 0, doneCnt = 0;

  // slave model state
  logic [31:0] ctrlReg = '0;
  logic [31:0] curTarget = '0;
  int busyLeft = 0, busyDepth = 0, failTarget = -1;
  int pendCnt = 0;
  logic [31:0] pendData = '0;
  int logN = 0;
  logic [5:0]  logAddr [LOG_MAX];
  logic [31:0] logData [LOG_MAX];
  logic        logRd   [LOG_MAX];
  int expN = 0;
  logic [5:0]  expAddr [LOG_MAX];
  logic [31:0] expData [LOG_MAX];
  logic        expRd   [LOG_MAX];

  always @(posedge clk) begin
    avReadValid <= 1'b0;
    if (pendCnt != 0) begin
      pendCnt <= pendCnt - 1;
      if (pendCnt == 1) begin
        avReadValid <= 1'b1;
        avReadData <= pendData;
      end
    end
    if (avRead && !avWaitReq) begin
      if (logN < LOG_MAX) begin
        logAddr[logN] <= avAddr; logData[logN] <= '0; logRd[logN] <= 1'b1;
      end
      logN <= logN + 1;
      pendData <= ctrlReg | ((busyLeft > 0) ? 32'h100 : 32'h0);
      if (busyLeft > 0) busyLeft <= busyLeft - 1;
      pendCnt <= 1 + int'($urandom % 3);
    end
    if (avWrite && !avWaitReq) begin
      if (logN < LOG_MAX) begin
        logAddr[logN] <= avAddr; logData[logN] <= avWriteData; logRd[logN] <= 1'b0;
      end
      logN <= logN + 1;
      if (avAddr == 6'h38) curTarget <= avWriteData;
      if (avAddr == 6'h3A) begin
        ctrlReg <= avWriteData & ~32'h101;
        if (avWriteData[0])
          busyLeft <= (int'(curTarget) == failTarget) ? 100000 : busyDepth;
      end
    end
    avWaitReq <= (($urandom % 4) == 0);
  end

  always @(negedge clk) begin
    cycles <= cycles + 1;
    if (done) doneCnt <= doneCnt + 1;
  end

  initial begin
    #(8 * 150000);
    total++; bad++;
    $display("FAIL watchdog: run did not finish (actual hung, expected finish)");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic addExp(input bit rd, input logic [5:0] a, input logic [31:0] d);
    if (expN < LOG_MAX) begin expRd[expN] = rd; expAddr[expN] = a; expData[expN] = d; end
    expN++;
  endtask

  // expected access stream from R1..R4
  task automatic buildExp(input int lanes, input logic [31:0] init, input int depth);
    logic [31:0] m;
    m = init & ~32'hC;
    expN = 0;
    for (int k = 0; k < 2 * lanes; k++) begin
      addExp(0, 6'h38, k);
      addExp(1, 6'h3A, 0);
      addExp(0, 6'h3A, m);
      addExp(0, 6'h3B, 0);
      addExp(0, 6'h3C, BASE);
      addExp(0, 6'h3A, m | 1);
      for (int p = 0; p <= depth; p++) addExp(1, 6'h3A, 0);
      addExp(0, 6'h3B, 1);
      addExp(0, 6'h3C, 3);
      addExp(0, 6'h3A, m | 1);
      for (int p = 0; p <= depth; p++) addExp(1, 6'h3A, 0);
    end
  endtask

  function automatic string tagOf(input logic [5:0] a, input logic rd);
    if (a == 6'h38) return "R1";
    if (rd) return "R4";
    if (a == 6'h3A) return "R3";
    return "R2";
  endfunction

  task automatic pulseStart(input int lanes);
    @(negedge clk);
    laneCount = lanes[LANE_W-1:0];
    startReq = 1'b1;
    @(negedge clk);
    startReq = 1'b0;
  endtask

  task automatic runSeq(input int lanes, input int depth, input int failT,
                        input int limit, input bit midStart);
    logic [31:0] init;
    int t0, n0, lim;
    init = $urandom & ~32'h101;
    @(negedge clk);
    ctrlReg = init; busyDepth = depth; failTarget = failT;
    pollLimit = limit[TMO_W-1:0];
    logN = 0; doneCnt = 0;
    pulseStart(lanes);
    if (midStart) begin
      repeat (25) @(negedge clk);
      pulseStart(1); // R8: must be ignored
    end
    t0 = cycles;
    while (!(done || error) && (cycles - t0) < 20000) @(negedge clk);
    repeat (20) @(negedge clk);
    if (failT < 0) begin
      buildExp(lanes, init, depth);
      check(doneCnt == 1, midStart ? "R8 done count" : "R7 done count", doneCnt, 1);
      check(!error, "R6 no error on clean run", error, 0);
      check(logN == expN, midStart ? "R8 access count" : "R2 access count", logN, expN);
      for (int i = 0; i < expN && i < logN && i < LOG_MAX; i++) begin
        check(logRd[i] == expRd[i] && logAddr[i] == expAddr[i] &&
              (expRd[i] || logData[i] == expData[i]),
              tagOf(expAddr[i], expRd[i]),
              {logRd[i], 1'b0, logAddr[i], logData[i][23:0]},
              {expRd[i], 1'b0, expAddr[i], expData[i][23:0]});
      end
    end else begin
      check(error, "R6 error raised", error, 1);
      check(int'(failIndex) == failT, "R6 failIndex", failIndex, failT);
      check(doneCnt == 0, "R6 no done", doneCnt, 0);
      n0 = logN;
      repeat (30) @(negedge clk);
      check(logN == n0, "R6 bus silent after halt", logN, n0);
      check(error, "R6 error held", error, 1);
      lim = 0;
      for (int i = 0; i < logN && i < LOG_MAX; i++)
        if (logRd[i] && i > 0 && logAddr[i] == 6'h3A && !logRd[i-1]) lim = 0;
      busyLeft = 0;
    end
  endtask

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    check(!done && !error && !avWrite && !avRead, "R9 reset outputs",
          {done, error, avWrite, avRead}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!done && !error && !avWrite && !avRead, "R9 idle after reset",
          {done, error, avWrite, avRead}, 0);

    // directed corners
    runSeq(1, 0, -1, 8, 0);          // smallest run
    runSeq(4, 3, -1, 8, 0);          // widest run, deep busy
    runSeq(2, 1, -1, 8, 1);          // R8 start during run
    // R7 zero lanes: done pulse, no access
    logN = 0; doneCnt = 0;
    pulseStart(0);
    repeat (10) @(negedge clk);
    check(doneCnt == 1, "R7 zero lanes done", doneCnt, 1);
    check(logN == 0, "R7 zero lanes no access", logN, 0);
    // R6 timeouts: first channel and last PLL
    runSeq(2, 0, 0, 3, 0);
    runSeq(3, 0, 5, 3, 0);
    // restart after halt clears error
    runSeq(1, 2, -1, 8, 0);
    // constrained random clean runs
    for (int r = 0; r < 6; r++)
      runSeq(1 + int'($urandom % 4), int'($urandom % 4), -1, 8, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule